// File: doc/BRIEF.md
# Wide Vector Register File with Upper-Zeroing Writes

This block holds the architectural vector registers of a SIMD datapath. There are 32 registers by default. Each one is 512 bits wide and is treated as four 128-bit lanes, or as two 256-bit halves. Every cycle the block accepts at most one write and serves two independent combinational read ports. All registers come out of reset as zero.

A write carries a register index, a 512-bit data word, a write kind and a 2-bit vector-length code. The kind says which bits take new data. The vector-length code says whether the bits above the written width are kept or forced to zero. This lets one storage array serve three kinds of writer:
- legacy 128-bit operations, which must preserve the upper bits;
- 128-bit and 256-bit operations, which must zero everything above their width;
- scalar operations, which touch only a low element.

Each read port returns one of four views of a register:
- the whole register;
- one 128-bit lane;
- the low 64 bits;
- one 256-bit half.

Each read port also flags when the low 128 bits of the addressed register are all zero.

Top module: `vreg_file`

## Requirements
- R1: After reset every register reads as zero on both ports, and both zero flags are 1.
- R2: Write kind 0 (full) stores all 512 data bits into the addressed register.
- R3: Write kind 1 (128-bit) stores data bits 127:0 into register bits 127:0. With vector-length code 0, register bits 511:128 are kept. With any other code, bits 511:128 become zero.
- R4: Write kind 2 (256-bit) stores data bits 255:0 into register bits 255:0.
  - Code 2 (256) zeroes bits 511:256.
  - Code 1 (128) zeroes bits 511:128, including the freshly written bits 255:128.
  - Codes 0 and 3 keep bits 511:256.
- R5: Write kinds 3, 4, 5 and 6 store the low 8, 16, 32 or 64 data bits into the same low register bits, and keep every other register bit.
- R6: Write kind 7 stores data bits 63:0 into register bits 63:0 and zeroes register bits 511:64.
- R7: Write kind 8 stores data bits 63:0 into register bits 127:64 and keeps all other register bits.
- R8: Write kind 9 zeroes all 512 bits of the addressed register.
- R9: Write kind 10 writes no data. It only zeroes by vector-length code: code 2 zeroes bits 511:256, code 1 zeroes bits 511:128, and codes 0 and 3 change nothing.
- R10: Write kinds 11 to 15 leave the register unchanged. A write with the write enable low changes no register.
- R11: The read mode selects what a port returns; every view other than mode 0 is zero-extended to 512 bits.
  - Mode 0 returns the full register.
  - Mode 1 returns lane n (bits 128n+127:128n, n from the 2-bit select).
  - Mode 2 returns bits 63:0.
  - Mode 3 returns half h (bits 256h+255:256h, h from select bit 0).
- R12: A read of the register being written in the same cycle returns the value before the write. The new value is visible from the next cycle.
- R13: A port's zero flag is 1 exactly when bits 127:0 of the addressed register are all zero, whatever the read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register written |
| wr_kind | input | 4 | Write kind code |
| wr_vl | input | 2 | Vector-length code (0 none, 1 = 128, 2 = 256, 3 = 512) |
| wr_data | input | 512 | Write data |
| p0_idx | input | 5 | Port 0 register index |
| p0_mode | input | 2 | Port 0 view mode |
| p0_sel | input | 2 | Port 0 lane or half select |
| p0_data | output | 512 | Port 0 read data |
| p0_zero | output | 1 | Port 0 low-128 zero flag |
| p1_idx | input | 5 | Port 1 register index |
| p1_mode | input | 2 | Port 1 view mode |
| p1_sel | input | 2 | Port 1 lane or half select |
| p1_data | output | 512 | Port 1 read data |
| p1_zero | output | 1 | Port 1 low-128 zero flag |

## Verification
A write and a read can address the same register in the same cycle.

The bench provokes this by sending a full write to a register while one port reads it. It expects the value from before the write, and it expects the new contents on the following cycle.

Every other write kind is followed by a read of the target. A reference image of all registers, built only from the requirements, predicts each port's data and zero flag. Those predictions are queued and compared as results appear.

// File: rtl/vreg_file.sv
module vreg_file #(
  parameter int NREG   = 32,
  parameter int LANE_W = 128,
  parameter int LANES  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(NREG)-1:0]     wr_idx,
  input  logic [3:0]                  wr_kind,
  input  logic [1:0]                  wr_vl,
  input  logic [LANE_W*LANES-1:0]     wr_data,
  input  logic [$clog2(NREG)-1:0]     p0_idx,
  input  logic [1:0]                  p0_mode,
  input  logic [$clog2(LANES)-1:0]    p0_sel,
  output logic [LANE_W*LANES-1:0]     p0_data,
  output logic                        p0_zero,
  input  logic [$clog2(NREG)-1:0]     p1_idx,
  input  logic [1:0]                  p1_mode,
  input  logic [$clog2(LANES)-1:0]    p1_sel,
  output logic [LANE_W*LANES-1:0]     p1_data,
  output logic                        p1_zero
);
  localparam int VW   = LANE_W * LANES;
  localparam int HALF = VW / 2;
  localparam int QW   = LANE_W / 2;
  localparam int SW   = $clog2(LANES);

  localparam logic [VW-1:0] ONES    = '1;
  localparam logic [VW-1:0] M_LANE0 = ONES >> (VW - LANE_W);
  localparam logic [VW-1:0] M_HALF0 = ONES >> HALF;
  localparam logic [VW-1:0] M_Q     = ONES >> (VW - QW);
  localparam logic [VW-1:0] M_D     = ONES >> (VW - 32);
  localparam logic [VW-1:0] M_W     = ONES >> (VW - 16);
  localparam logic [VW-1:0] M_B     = ONES >> (VW - 8);

  localparam logic [3:0] K_FULL = 4'd0, K_X128 = 4'd1, K_Y256 = 4'd2,
                         K_B8   = 4'd3, K_W16  = 4'd4, K_D32  = 4'd5,
                         K_Q64  = 4'd6, K_QZ   = 4'd7, K_HIQ  = 4'd8,
                         K_CLR  = 4'd9, K_ZVL  = 4'd10;
  localparam logic [1:0] VL_NONE = 2'd0, VL_128 = 2'd1, VL_256 = 2'd2;

  logic [VW-1:0] regs [NREG];
  logic [VW-1:0] old, wd, wmask, zmask, vl_zero, nxt;

  assign vl_zero = (wr_vl == VL_256) ? ~M_HALF0 :
                   (wr_vl == VL_128) ? ~M_LANE0 : '0;

  always_comb begin
    old   = regs[wr_idx];
    wd    = wr_data;
    wmask = '0;
    zmask = '0;
    case (wr_kind)
      K_FULL: wmask = ONES;
      K_X128: begin
        wmask = M_LANE0;
        if (wr_vl != VL_NONE) zmask = ~M_LANE0;
      end
      K_Y256: begin
        wmask = M_HALF0;
        zmask = vl_zero;
      end
      K_B8:   wmask = M_B;
      K_W16:  wmask = M_W;
      K_D32:  wmask = M_D;
      K_Q64:  wmask = M_Q;
      K_QZ: begin
        wmask = M_Q;
        zmask = ~M_Q;
      end
      K_HIQ: begin
        wmask = M_Q << QW;
        wd    = wr_data << QW;
      end
      K_CLR:  zmask = ONES;
      K_ZVL:  zmask = vl_zero;
      default: ;
    endcase
    nxt = ((old & ~wmask) | (wd & wmask)) & ~zmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_idx] <= nxt;
    end
  end

  function automatic logic [VW-1:0] view(input logic [VW-1:0] r,
                                         input logic [1:0] m,
                                         input logic [SW-1:0] s);
    case (m)
      2'd0:    view = r;
      2'd1:    view = VW'(r[s*LANE_W +: LANE_W]);
      2'd2:    view = VW'(r[QW-1:0]);
      default: view = VW'(r[s[0]*HALF +: HALF]);
    endcase
  endfunction

  assign p0_data = view(regs[p0_idx], p0_mode, p0_sel);
  assign p1_data = view(regs[p1_idx], p1_mode, p1_sel);
  assign p0_zero = ~|regs[p0_idx][LANE_W-1:0];
  assign p1_zero = ~|regs[p1_idx][LANE_W-1:0];
endmodule

// File: rtl/vreg_file_chk.sv
module vreg_file_chk #(
  parameter int NREG   = 32,
  parameter int LANE_W = 128,
  parameter int LANES  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [$clog2(NREG)-1:0]       wr_idx,
  input logic [3:0]                    wr_kind,
  input logic [1:0]                    wr_vl,
  input logic [LANE_W*LANES/2-1:0]     wr_lo,
  input logic [1:0]                    p0_mode,
  input logic [LANE_W*LANES-1:LANE_W]  p0_hi,
  input logic [LANE_W*LANES-1:0]       mem [NREG]
);
  localparam int VW   = LANE_W * LANES;
  localparam int HALF = VW / 2;
  localparam int QW   = LANE_W / 2;
  localparam logic [VW-1:0] ONES    = '1;
  localparam logic [VW-1:0] M_LANE0 = ONES >> (VW - LANE_W);
  localparam logic [VW-1:0] M_HALF0 = ONES >> HALF;
  localparam logic [VW-1:0] M_BYTE  = ONES >> (VW - 8);
  localparam logic [VW-1:0] M_HIQ   = (ONES >> (VW - QW)) << QW;

  logic                    we_q;
  logic [$clog2(NREG)-1:0] idx_q;
  logic [3:0]              kind_q;
  logic [1:0]              vl_q;
  logic [HALF-1:0]         data_q;
  logic [VW-1:0]           old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0; idx_q <= '0; kind_q <= '0; vl_q <= '0;
      data_q <= '0; old_q <= '0;
    end else begin
      we_q <= wr_en; idx_q <= wr_idx; kind_q <= wr_kind; vl_q <= wr_vl;
      data_q <= wr_lo; old_q <= mem[wr_idx];
    end
  end

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q && kind_q == 4'd9) |-> (mem[idx_q] == '0));

  p_legacy_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q && kind_q == 4'd1 && vl_q == 2'd0) |->
    ((mem[idx_q] & ~M_LANE0) == (old_q & ~M_LANE0)) &&
    (mem[idx_q][LANE_W-1:0] == data_q[LANE_W-1:0]));

  p_vl256_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q && kind_q == 4'd2 && vl_q == 2'd2) |->
    (mem[idx_q] == VW'(data_q)));

  p_low_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q && kind_q == 4'd3) |->
    ((mem[idx_q] & ~M_BYTE) == (old_q & ~M_BYTE)));

  p_hiq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q && kind_q == 4'd8) |->
    ((mem[idx_q] & ~M_HIQ) == (old_q & ~M_HIQ)) &&
    (mem[idx_q][LANE_W-1:QW] == data_q[QW-1:0]));

  p_lane_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_mode == 2'd1) |-> (p0_hi == '0));
endmodule

bind vreg_file vreg_file_chk #(.NREG(NREG), .LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_kind(wr_kind), .wr_vl(wr_vl),
  .wr_lo(wr_data[LANE_W*LANES/2-1:0]),
  .p0_mode(p0_mode), .p0_hi(p0_data[LANE_W*LANES-1:LANE_W]),
  .mem(regs)
);

// File: tb/vreg_file_tb.sv
module vreg_file_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         wr_en = 1'b0;
  logic [4:0]   wr_idx = '0;
  logic [3:0]   wr_kind = '0;
  logic [1:0]   wr_vl = '0;
  logic [511:0] wr_data = '0;
  logic [4:0]   p0_idx = '0, p1_idx = '0;
  logic [1:0]   p0_mode = '0, p1_mode = '0, p0_sel = '0, p1_sel = '0;
  logic [511:0] p0_data, p1_data;
  logic         p0_zero, p1_zero;

  vreg_file u_dut (.*);

  typedef struct {
    logic [511:0] a; logic za; logic [511:0] b; logic zb; string tag;
  } exp_t;
  exp_t q[$];
  logic [511:0] mdl [32];
  int checks = 0, bad = 0;
  bit done = 0;

  function automatic logic [511:0] pat(input logic [7:0] s);
    logic [511:0] p;
    for (int i = 0; i < 16; i++) p[i*32 +: 32] = {s, 8'(i + 1), 16'hC3A5 ^ {s, s}};
    return p;
  endfunction

  function automatic logic [511:0] zr(input logic [511:0] m, input logic [1:0] vl);
    if (vl == 2'd2) m[511:256] = '0;
    else if (vl == 2'd1) m[511:128] = '0;
    return m;
  endfunction

  function automatic logic [511:0] see(input logic [511:0] m, input logic [1:0] md,
                                       input logic [1:0] s);
    case (md)
      2'd0: return m;
      2'd1: return {384'd0, m[s*128 +: 128]};
      2'd2: return {448'd0, m[63:0]};
      default: return {256'd0, m[s[0]*256 +: 256]};
    endcase
  endfunction

  task automatic op(input bit we, input logic [3:0] k, input logic [1:0] vl,
                    input logic [4:0] wi, input logic [511:0] d,
                    input logic [4:0] ai, input logic [1:0] am, input logic [1:0] as_,
                    input logic [4:0] bi, input logic [1:0] bm, input logic [1:0] bs,
                    input string tag);
    exp_t e;
    logic [511:0] m;
    @(negedge clk);
    wr_en = we; wr_kind = k; wr_vl = vl; wr_idx = wi; wr_data = d;
    p0_idx = ai; p0_mode = am; p0_sel = as_;
    p1_idx = bi; p1_mode = bm; p1_sel = bs;
    e.a = see(mdl[ai], am, as_); e.za = (mdl[ai][127:0] == '0);
    e.b = see(mdl[bi], bm, bs); e.zb = (mdl[bi][127:0] == '0);
    e.tag = tag;
    q.push_back(e);
    if (we) begin
      m = mdl[wi];
      case (k)
        4'd0: m = d;
        4'd1: begin m[127:0] = d[127:0]; if (vl != 2'd0) m[511:128] = '0; end
        4'd2: begin m[255:0] = d[255:0]; m = zr(m, vl); end
        4'd3: m[7:0] = d[7:0];
        4'd4: m[15:0] = d[15:0];
        4'd5: m[31:0] = d[31:0];
        4'd6: m[63:0] = d[63:0];
        4'd7: m = {448'd0, d[63:0]};
        4'd8: m[127:64] = d[63:0];
        4'd9: m = '0;
        4'd10: m = zr(m, vl);
        default: ;
      endcase
      mdl[wi] = m;
    end
  endtask

  task automatic wr(input logic [3:0] k, input logic [1:0] vl, input logic [4:0] wi,
                    input logic [511:0] d, input string tag);
    op(1'b1, k, vl, wi, d, 5'd0, 2'd0, 2'd0, 5'd31, 2'd0, 2'd0, tag);
  endtask

  task automatic rd(input logic [4:0] ai, input logic [1:0] am, input logic [1:0] as_,
                    input logic [4:0] bi, input logic [1:0] bm, input logic [1:0] bs,
                    input string tag);
    op(1'b0, 4'd0, 2'd0, 5'd0, pat(8'hEE), ai, am, as_, bi, bm, bs, tag);
  endtask

  task automatic cmp(input logic [511:0] act, input logic [511:0] exp, input string what,
                     input string tag);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(p0_data, e.a, "p0_data", e.tag);
        cmp(512'(p0_zero), 512'(e.za), "p0_zero", e.tag);
        cmp(p1_data, e.b, "p1_data", e.tag);
        cmp(512'(p1_zero), 512'(e.zb), "p1_zero", e.tag);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(5'd0, 2'd0, 2'd0, 5'd31, 2'd0, 2'd0, "R1 reset zero");
    rd(5'd17, 2'd1, 2'd3, 5'd9, 2'd3, 2'd1, "R1 reset zero views");
    op(1'b1, 4'd0, 2'd0, 5'd3, pat(8'h11), 5'd3, 2'd0, 2'd0, 5'd3, 2'd1, 2'd0, "R12 old value same cycle");
    rd(5'd3, 2'd0, 2'd0, 5'd3, 2'd1, 2'd2, "R2 full write");
    wr(4'd1, 2'd0, 5'd3, pat(8'h22), "R3 legacy write");
    rd(5'd3, 2'd0, 2'd0, 5'd3, 2'd3, 2'd1, "R3 upper kept");
    wr(4'd1, 2'd1, 5'd3, pat(8'h33), "R3 vl write");
    rd(5'd3, 2'd0, 2'd0, 5'd3, 2'd1, 2'd1, "R3 upper zeroed");
    wr(4'd1, 2'd3, 5'd2, pat(8'h34), "R3 vl3 write");
    rd(5'd2, 2'd0, 2'd0, 5'd2, 2'd1, 2'd0, "R3 vl3 upper zeroed");
    for (int v = 0; v < 4; v++) begin
      wr(4'd0, 2'd0, 5'd4, pat(8'h44), "R4 preload");
      wr(4'd2, 2'(v), 5'd4, pat(8'h55), "R4 256 write");
      rd(5'd4, 2'd0, 2'd0, 5'd4, 2'd3, 2'd1, "R4 256 result");
    end
    wr(4'd0, 2'd0, 5'd6, pat(8'h61), "R5 preload");
    for (int k = 3; k <= 6; k++) begin
      wr(4'(k), 2'd1, 5'd6, pat(8'(8'h70 + k)), "R5 low element");
      rd(5'd6, 2'd0, 2'd0, 5'd6, 2'd2, 2'd0, "R5 low element result");
    end
    wr(4'd0, 2'd0, 5'd7, pat(8'h81), "R6 preload");
    wr(4'd7, 2'd0, 5'd7, pat(8'h82), "R6 qword zero write");
    rd(5'd7, 2'd0, 2'd0, 5'd7, 2'd1, 2'd1, "R6 qword zero result");
    wr(4'd0, 2'd0, 5'd8, pat(8'h91), "R7 preload");
    wr(4'd8, 2'd2, 5'd8, pat(8'h92), "R7 high qword write");
    rd(5'd8, 2'd0, 2'd0, 5'd8, 2'd1, 2'd0, "R7 high qword result");
    wr(4'd0, 2'd0, 5'd9, pat(8'hA1), "R8 preload");
    wr(4'd9, 2'd0, 5'd9, pat(8'hA2), "R8 clear");
    rd(5'd9, 2'd0, 2'd0, 5'd9, 2'd3, 2'd1, "R8 clear result");
    for (int v = 0; v < 4; v++) begin
      wr(4'd0, 2'd0, 5'd10, pat(8'hB1), "R9 preload");
      wr(4'd10, 2'(v), 5'd10, pat(8'hB2), "R9 zero by vl");
      rd(5'd10, 2'd0, 2'd0, 5'd10, 2'd3, 2'd1, "R9 zero by vl result");
    end
    wr(4'd0, 2'd0, 5'd11, pat(8'hC1), "R10 preload");
    for (int k = 11; k < 16; k++) begin
      wr(4'(k), 2'd1, 5'd11, pat(8'hC2), "R10 unused kind");
      rd(5'd11, 2'd0, 2'd0, 5'd11, 2'd2, 2'd0, "R10 unused kind no change");
    end
    op(1'b0, 4'd9, 2'd0, 5'd11, pat(8'hC3), 5'd0, 2'd0, 2'd0, 5'd0, 2'd0, 2'd0, "R10 disabled");
    rd(5'd11, 2'd0, 2'd0, 5'd11, 2'd1, 2'd3, "R10 disabled no change");
    wr(4'd0, 2'd0, 5'd12, pat(8'hD1), "R11 preload");
    for (int s = 0; s < 4; s++) begin
      rd(5'd12, 2'd1, 2'(s), 5'd12, 2'd3, 2'(s), "R11 lane and half views");
    end
    rd(5'd12, 2'd2, 2'd3, 5'd12, 2'd0, 2'd2, "R11 low64 and full views");
    wr(4'd0, 2'd0, 5'd13, {384'hF00D, 128'd0}, "R13 preload");
    rd(5'd13, 2'd0, 2'd0, 5'd13, 2'd2, 2'd0, "R13 low zero upper set");
    wr(4'd8, 2'd0, 5'd13, {448'd0, 64'h8000_0000_0000_0000}, "R13 set bit 127");
    rd(5'd13, 2'd1, 2'd3, 5'd13, 2'd0, 2'd0, "R13 bit 127 only");
    op(1'b1, 4'd0, 2'd0, 5'd14, pat(8'hE1), 5'd14, 2'd3, 2'd1, 5'd14, 2'd0, 2'd0, "R12 both ports old");
    rd(5'd14, 2'd0, 2'd0, 5'd14, 2'd1, 2'd2, "R12 new value next cycle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule